// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Controller

This block gathers interrupt events from three edge-sensitive external pins, a timer overflow and a four-pin port change detector. Each event sets a sticky flag that only software can clear. Each flag is gated by its own enable bit. Every enabled flag is then steered to a high-priority or a low-priority request line by a per-source priority bit. External pin 0 has no priority bit and always goes to the high line.

The block also drives two further outputs. A wake output asks a sleeping core to resume whenever any enabled flag is pending. A vector-branch output asks the core to take the interrupt, and it needs the global enable as well. Software reaches flags, enables, edge polarity, timer width, priorities and the port change mask through a small register port with separate write and read strobes. The timer counter itself lives outside: the block only sees its value and its increment strobe.

Source indices are: 0, 1 and 2 for external pins 0 to 2, 3 for the timer, and 4 for the port change detector. The register offsets are listed below. FLAG is at 0: bits 4:0 hold the flags. ENA is at 1: bits 4:0 hold the enables and bit 7 is the global enable. CFG is at 2: bits 2:0 select the edge per pin (1 = rising) and bit 7 selects 16-bit timer mode. PRIO is at 3: bits 4:1 hold the priority per source (1 = high), and bit 0 always reads 1. CMASK is at 4: bits 3:0 hold the per-pin change mask. PORT is at 5: it reads the synchronized port pins.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, FLAG, ENA and CMASK read 0, CFG reads 0x07 and PRIO reads 0x1F, and irq_hi_o, irq_lo_o, wake_o and vec_o are all 0.
- R2: An external pin sets its flag only on the edge chosen by its CFG bit (1 = rising, 0 = falling). The flag is visible at the third rising clock edge after the pin changes.
- R3: A flag stays set until software writes FLAG with a 0 in that bit position. Writing a 1 never clears a flag and never sets one.
- R4: If a flag-set event and a clearing write to FLAG happen in the same cycle, the flag ends up set. The other flags cleared by that write still clear.
- R5: A pending flag whose enable bit is 0 drives none of irq_hi_o, irq_lo_o or wake_o, but it still reads back as 1 in FLAG.
- R6: Source 0 routes to irq_hi_o whatever is written to PRIO. PRIO bit 0 always reads 1.
- R7: For sources 1 to 4, an enabled pending flag drives irq_hi_o when its PRIO bit is 1 and irq_lo_o when its PRIO bit is 0.
- R8: With CFG bit 7 = 0, a timer increment while tmr_val_i[7:0] is 0xFF sets flag 3, whatever the upper byte holds. With CFG bit 7 = 1, only 0xFFFF sets it. No increment means no set.
- R9: A change on a port pin sets the shared flag 4 only when that pin's CMASK bit is 1. A read of PORT returns the synchronized pin levels in bits 3:0.
- R10: The port change detector compares the pins with a snapshot taken at the last read of PORT. Until PORT is read again, a clear of flag 4 is overridden by the still-present difference.
- R11: wake_o is 1 whenever any enabled flag is pending, whatever the global enable. vec_o is 1 only when wake_o is 1 and ENA bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 3 | External interrupt pins, asynchronous |
| port_pin_i | input | 4 | Port pins watched for change, asynchronous |
| tmr_inc_i | input | 1 | Timer increments this cycle |
| tmr_val_i | input | 16 | Current timer value before the increment |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a read of PORT refreshes the snapshot) |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_hi_o | output | 1 | High-priority interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| wake_o | output | 1 | Wake request to a sleeping core |
| vec_o | output | 1 | Vector-branch request |

## Verification
The bound checker watches several rules on every cycle. A flag may only rise after a set event, and it may only fall after a write to FLAG. A set event always lands in its flag. Source 0 never drives the low line. The wake and vector outputs must agree with the enabled flags and the global enable. A timer wrap in either mode must set flag 3. Other behaviour only shows up across a scenario, so the bench covers it: the polarity chosen per pin, the three-cycle synchronizer latency, the PORT snapshot that keeps re-raising flag 4 until it is read, the per-pin change mask, and register read-back such as PRIO bit 0 ignoring writes.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned REG_AW = 3;
   localparam int unsigned REG_DW = 8;

   typedef enum logic [REG_AW-1:0] {
      A_FLAG  = 3'd0,
      A_ENA   = 3'd1,
      A_CFG   = 3'd2,
      A_PRIO  = 3'd3,
      A_CMASK = 3'd4,
      A_PORT  = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
module irq_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q <= '0;
            else         stg_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q <= '0;
            else         stg_q <= {stg_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
// Edge detector with a selectable polarity for one synchronized pin.
module irq_edge_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic rise_sel_i,
   output logic hit_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   assign hit_o = rise_sel_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
endmodule

// File: rtl/irq_tmr_ovf.sv
// Timer wrap detector, narrow or full-width compare.
module irq_tmr_ovf #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic             inc_i,
   input  logic             wide_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             hit_o
);
   logic narrow_top;
   logic full_top;

   assign narrow_top = &cnt_i[NARROW_W-1:0];

   generate
      if (CNT_W > NARROW_W) begin : g_wide
         assign full_top = &cnt_i;
      end else begin : g_narrow_only
         assign full_top = narrow_top;
      end
   endgenerate

   assign hit_o = inc_i & (wide_i ? full_top : narrow_top);
endmodule

// File: rtl/irq_port_chg.sv
// Port change detector: difference against a snapshot refreshed on demand.
module irq_port_chg #(
   parameter int unsigned PINS = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PINS-1:0] lvl_i,
   input  logic [PINS-1:0] mask_i,
   input  logic            snap_i,
   output logic            hit_o
);
   logic [PINS-1:0] snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     snap_q <= '0;
      else if (snap_i) snap_q <= lvl_i;
   end

   assign hit_o = |((lvl_i ^ snap_q) & mask_i);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_EXT     = 3,
   parameter int unsigned NUM_CHG     = 4,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned NARROW_W    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_EXT-1:0]  ext_pin_i,
   input  logic [NUM_CHG-1:0]  port_pin_i,
   input  logic                tmr_inc_i,
   input  logic [CNT_W-1:0]    tmr_val_i,
   input  logic                wr_en_i,
   input  logic                rd_en_i,
   input  logic [REG_AW-1:0]   addr_i,
   input  logic [REG_DW-1:0]   wdata_i,
   output logic [REG_DW-1:0]   rdata_o,
   output logic                irq_hi_o,
   output logic                irq_lo_o,
   output logic                wake_o,
   output logic                vec_o
);
   localparam int unsigned NSRC    = NUM_EXT + 2;
   localparam int unsigned SRC_TMR = NUM_EXT;
   localparam int unsigned SRC_CHG = NUM_EXT + 1;
   localparam int unsigned SYNC_W  = NUM_EXT + NUM_CHG;

   // elaboration-time parameter checks
   generate
      if (NUM_EXT < 1 || NUM_EXT > 5) begin : g_bad_ext
         $error("NUM_EXT must lie in 1..5");
      end
      if (NUM_CHG < 1 || NUM_CHG > REG_DW) begin : g_bad_chg
         $error("NUM_CHG must lie in 1..REG_DW");
      end
      if (NARROW_W < 1 || CNT_W < NARROW_W) begin : g_bad_cnt
         $error("need 1 <= NARROW_W <= CNT_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // configuration state
   logic [NSRC-1:0]    flag_q;
   logic [NSRC-1:0]    en_q;
   logic               gie_q;
   logic [NUM_EXT-1:0] edge_q;
   logic               wide_q;
   logic [NSRC-1:1]    prio_q;
   logic [NUM_CHG-1:0] mask_q;

   logic [NSRC-1:0]    set_vec;
   logic [NSRC-1:0]    prio_eff;
   logic [NSRC-1:0]    act;
   logic [SYNC_W-1:0]  sync_out;
   logic [NUM_EXT-1:0] ext_s;
   logic [NUM_CHG-1:0] port_s;
   logic               wr_flag, wr_ena, wr_cfg, wr_prio, wr_mask, snap_rd;
   logic [REG_DW-1:0]  unused_wdata;

   assign unused_wdata = wdata_i;

   // input synchronization
   irq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({port_pin_i, ext_pin_i}),
      .q_o   (sync_out)
   );
   assign ext_s  = sync_out[NUM_EXT-1:0];
   assign port_s = sync_out[NUM_EXT +: NUM_CHG];

   // event sources
   generate
      for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
         irq_edge_det u_edge (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .lvl_i     (ext_s[i]),
            .rise_sel_i(edge_q[i]),
            .hit_o     (set_vec[i])
         );
      end
   endgenerate

   irq_tmr_ovf #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_tmr (
      .inc_i (tmr_inc_i),
      .wide_i(wide_q),
      .cnt_i (tmr_val_i),
      .hit_o (set_vec[SRC_TMR])
   );

   assign snap_rd = rd_en_i && (addr_i == A_PORT);

   irq_port_chg #(.PINS(NUM_CHG)) u_chg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (port_s),
      .mask_i(mask_q),
      .snap_i(snap_rd),
      .hit_o (set_vec[SRC_CHG])
   );

   // register writes
   assign wr_flag = wr_en_i && (addr_i == A_FLAG);
   assign wr_ena  = wr_en_i && (addr_i == A_ENA);
   assign wr_cfg  = wr_en_i && (addr_i == A_CFG);
   assign wr_prio = wr_en_i && (addr_i == A_PRIO);
   assign wr_mask = wr_en_i && (addr_i == A_CMASK);

   // flags: a software clear is a write of 0; a set event in the same cycle wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= '0;
      else if (wr_flag) flag_q <= (flag_q & wdata_i[NSRC-1:0]) | set_vec;
      else              flag_q <= flag_q | set_vec;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '0;
         gie_q  <= 1'b0;
         edge_q <= '1;
         wide_q <= 1'b0;
         prio_q <= '1;
         mask_q <= '0;
      end else begin
         if (wr_ena) begin
            en_q  <= wdata_i[NSRC-1:0];
            gie_q <= wdata_i[REG_DW-1];
         end
         if (wr_cfg) begin
            edge_q <= wdata_i[NUM_EXT-1:0];
            wide_q <= wdata_i[REG_DW-1];
         end
         if (wr_prio) prio_q <= wdata_i[NSRC-1:1];
         if (wr_mask) mask_q <= wdata_i[NUM_CHG-1:0];
      end
   end

   // read mux
   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_FLAG:  rdata_o[NSRC-1:0] = flag_q;
         A_ENA: begin
            rdata_o[NSRC-1:0]  = en_q;
            rdata_o[REG_DW-1]  = gie_q;
         end
         A_CFG: begin
            rdata_o[NUM_EXT-1:0] = edge_q;
            rdata_o[REG_DW-1]    = wide_q;
         end
         A_PRIO:  rdata_o[NSRC-1:0]    = prio_eff;
         A_CMASK: rdata_o[NUM_CHG-1:0] = mask_q;
         A_PORT:  rdata_o[NUM_CHG-1:0] = port_s;
         default: rdata_o = '0;
      endcase
   end

   // routing: source 0 is fixed at high priority
   assign prio_eff = {prio_q, 1'b1};
   assign act      = flag_q & en_q;
   assign irq_hi_o = |(act & prio_eff);
   assign irq_lo_o = |(act & ~prio_eff);
   assign wake_o   = |act;
   assign vec_o    = wake_o & gie_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned NSRC     = 5,
   parameter int unsigned NUM_EXT  = 3,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned NARROW_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [NSRC-1:0]  flag_q,
   input logic [NSRC-1:0]  en_q,
   input logic             gie_q,
   input logic             wide_q,
   input logic [NSRC-1:0]  set_vec,
   input logic             wr_en_i,
   input logic [2:0]       addr_i,
   input logic             tmr_inc_i,
   input logic [CNT_W-1:0] tmr_val_i,
   input logic             irq_hi_o,
   input logic             irq_lo_o,
   input logic             wake_o,
   input logic             vec_o
);
   // R3: a flag rises only after a set event from its source
   p_rise_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));

   // R3: without a write to the flag register no flag falls
   p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && addr_i == 3'd0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R4: every set event lands, even against a clearing write
   p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

   // R5: no request lines without an enabled pending flag
   p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flag_q & en_q) == '0) |-> (!irq_hi_o && !irq_lo_o && !wake_o));

   // R6: source 0 always reaches the high line
   p_src0_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[0] && en_q[0]) |-> irq_hi_o);

   // R7: the low line needs an enabled pending flag other than source 0
   p_lo_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_lo_o |-> (((flag_q & en_q) >> 1) != '0));

   // R8: timer wrap in narrow mode
   p_tmr_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_inc_i && !wide_q && (&tmr_val_i[NARROW_W-1:0])) |=> flag_q[NUM_EXT]);

   // R8: timer wrap in wide mode
   p_tmr_wide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_inc_i && wide_q && (&tmr_val_i)) |=> flag_q[NUM_EXT]);

   // R11: wake follows enabled flags regardless of the global enable
   p_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flag_q & en_q) != '0) |-> wake_o);

   // R11: the branch request needs both wake and the global enable
   p_vec_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_o |-> (wake_o && gie_q));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NSRC    (NSRC),
   .NUM_EXT (NUM_EXT),
   .CNT_W   (CNT_W),
   .NARROW_W(NARROW_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .flag_q   (flag_q),
   .en_q     (en_q),
   .gie_q    (gie_q),
   .wide_q   (wide_q),
   .set_vec  (set_vec),
   .wr_en_i  (wr_en_i),
   .addr_i   (addr_i),
   .tmr_inc_i(tmr_inc_i),
   .tmr_val_i(tmr_val_i),
   .irq_hi_o (irq_hi_o),
   .irq_lo_o (irq_lo_o),
   .wake_o   (wake_o),
   .vec_o    (vec_o)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  ext_pin = '0;
   logic [3:0]  port_pin = '0;
   logic        tmr_inc = 1'b0;
   logic [15:0] tmr_val = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq_hi, irq_lo, wake, vec;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   irq_prio_ctrl dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .ext_pin_i (ext_pin),
      .port_pin_i(port_pin),
      .tmr_inc_i (tmr_inc),
      .tmr_val_i (tmr_val),
      .wr_en_i   (wr_en),
      .rd_en_i   (rd_en),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .irq_hi_o  (irq_hi),
      .irq_lo_o  (irq_lo),
      .wake_o    (wake),
      .vec_o     (vec)
   );

   // edge table: {pin[1:0], rise_sel, start, end, expected flag}
   localparam logic [5:0] EDGE_VEC [8] = '{
      {2'd0, 1'b1, 1'b0, 1'b1, 1'b1},
      {2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
      {2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
      {2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
      {2'd1, 1'b1, 1'b0, 1'b1, 1'b1},
      {2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
      {2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
      {2'd2, 1'b1, 1'b0, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pins(input logic [2:0] e, input logic [3:0] p);
      ext_pin = e; port_pin = p;
      repeat (4) @(negedge clk);
   endtask

   task automatic tpulse(input logic [15:0] v, input logic inc);
      tmr_val = v; tmr_inc = inc;
      @(negedge clk);
      tmr_inc = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, d); chk("R1 flags", d, 8'h00);
      rd(3'd1, d); chk("R1 enables", d, 8'h00);
      rd(3'd2, d); chk("R1 cfg", d, 8'h07);
      rd(3'd3, d); chk("R1 prio", d, 8'h1F);
      rd(3'd4, d); chk("R1 mask", d, 8'h00);
      chk("R1 outputs", {irq_hi, irq_lo, wake, vec}, 4'b0000);

      // R2 edge polarity table
      for (int k = 0; k < 8; k++) begin
         logic [1:0] pn;
         pn = EDGE_VEC[k][5:4];
         wr(3'd2, 8'(EDGE_VEC[k][3]) << pn);
         pins(3'(EDGE_VEC[k][2]) << pn, 4'h0);
         wr(3'd0, 8'h00);
         ext_pin = 3'(EDGE_VEC[k][1]) << pn;
         repeat (3) @(negedge clk);
         rd(3'd0, d);
         chk($sformatf("R2 edge vector %0d", k), d[pn], EDGE_VEC[k][0]);
      end
      wr(3'd2, 8'h07);
      pins(3'b000, 4'h0);
      wr(3'd0, 8'h00);

      // R3 sticky flag, clear only by writing 0
      pins(3'b001, 4'h0);
      pins(3'b000, 4'h0);
      rd(3'd0, d); chk("R3 flag held after pin drop", d, 8'h01);
      wr(3'd0, 8'hFF);
      rd(3'd0, d); chk("R3 write of 1 keeps flag", d, 8'h01);
      wr(3'd0, 8'hFE);
      rd(3'd0, d); chk("R3 write of 0 clears flag", d, 8'h00);

      // R5 / R11 enable and global gating
      pins(3'b001, 4'h0);
      rd(3'd0, d); chk("R5 flag readable while disabled", d, 8'h01);
      chk("R5 no requests while disabled", {irq_hi, irq_lo, wake}, 3'b000);
      wr(3'd1, 8'h01);
      chk("R11 wake without global enable", {wake, vec}, 2'b10);
      wr(3'd1, 8'h81);
      chk("R11 branch with global enable", {wake, vec}, 2'b11);
      pins(3'b000, 4'h0);
      wr(3'd0, 8'h00);

      // R6 / R7 priority routing
      wr(3'd1, 8'h03);
      wr(3'd3, 8'h00);
      rd(3'd3, d); chk("R6 prio bit0 fixed", d, 8'h01);
      pins(3'b010, 4'h0);
      chk("R7 low priority pin1", {irq_hi, irq_lo}, 2'b01);
      wr(3'd3, 8'h02);
      chk("R7 high priority pin1", {irq_hi, irq_lo}, 2'b10);
      wr(3'd3, 8'h00);
      pins(3'b000, 4'h0);
      wr(3'd0, 8'h00);
      pins(3'b001, 4'h0);
      chk("R6 pin0 high regardless of prio", {irq_hi, irq_lo}, 2'b10);
      pins(3'b000, 4'h0);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);

      // R8 timer wrap modes
      tpulse(16'h12FF, 1'b1);
      rd(3'd0, d); chk("R8 narrow wrap ignores upper byte", d, 8'h08);
      wr(3'd0, 8'h00);
      tpulse(16'h00FE, 1'b1);
      rd(3'd0, d); chk("R8 narrow no wrap", d, 8'h00);
      wr(3'd2, 8'h87);
      tpulse(16'h12FF, 1'b1);
      rd(3'd0, d); chk("R8 wide mode needs full wrap", d, 8'h00);
      tpulse(16'hFFFF, 1'b0);
      rd(3'd0, d); chk("R8 no increment no flag", d, 8'h00);
      tpulse(16'hFFFF, 1'b1);
      rd(3'd0, d); chk("R8 wide wrap", d, 8'h08);
      wr(3'd0, 8'h00);
      wr(3'd2, 8'h07);

      // R9 / R10 port change with mask and snapshot
      wr(3'd4, 8'h01);
      pins(3'b000, 4'h2);
      rd(3'd0, d); chk("R9 masked pin ignored", d, 8'h00);
      pins(3'b000, 4'h3);
      rd(3'd0, d); chk("R9 unmasked change sets flag", d, 8'h10);
      wr(3'd0, 8'h00);
      rd(3'd0, d); chk("R10 clear overridden before port read", d, 8'h10);
      rd(3'd5, d); chk("R9 port read value", d, 8'h03);
      wr(3'd0, 8'h00);
      repeat (3) @(negedge clk);
      rd(3'd0, d); chk("R10 clear holds after port read", d, 8'h00);

      // R4 set beats simultaneous clear
      pins(3'b001, 4'h3);
      tmr_val = 16'h00FF; tmr_inc = 1'b1;
      addr = 3'd0; wdata = 8'h00; wr_en = 1'b1;
      @(negedge clk);
      tmr_inc = 1'b0; wr_en = 1'b0;
      rd(3'd0, d); chk("R4 set wins, other flag cleared", d, 8'h08);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule